// File: doc/BRIEF.md
# Page Key Permission Guard

This block decides whether a single memory access may go ahead once the translation for it is known. It takes the leaf page-table entry that a walk or a TLB hit produced, the kind of access (read, write or instruction fetch) and the privilege mode of the requester. It then applies two independent screens. The first is the classic page screen, built from the present, writable and user bits of the entry. The second is a per-domain screen: a 4-bit domain number taken from the entry selects a two-bit permission pair inside a 32-bit per-thread permission register.

The access is granted only when both screens agree. A denial is reported as a fault, together with an error code. That code has its own bit marking a domain-key denial, so that an exception handler can tell it apart from an ordinary page fault. Software rewrites the permission register through a one-cycle write port, so rights can be revoked or granted without touching the page tables.

The result is registered. A small two-state machine sequences the output stage. `ST_IDLE` means no result is on the outputs. `ST_RESULT` means a verdict for the request of the previous cycle is being presented. The machine moves from `ST_IDLE` to `ST_RESULT` when `req_valid` is high, stays in `ST_RESULT` while requests keep arriving, and moves from `ST_RESULT` back to `ST_IDLE` on a cycle without a request.

Top module: `pkey_guard`

## Requirements
- R1: While and after reset, with no request given, `rsp_valid`, `rsp_allow`, `rsp_fault` and `rsp_code` are all 0. The permission register resets to all zeros, so every domain permits everything.
- R2: A request with `req_valid` high in cycle n yields `rsp_valid` high with its verdict in cycle n+1. In any cycle where `rsp_valid` is low, `rsp_allow`, `rsp_fault` and `rsp_code` are 0.
- R3: The page screen uses entry bit 0 (present), bit 1 (writable) and bit 2 (user page). A non-present entry faults. A user-mode access (`req_sup`=0) to a page with bit 2 clear faults. A write to a page with bit 1 clear faults in either mode.
- R4: The domain number is entry bits 62:59. For domain d, permission bit 2d is access-disable, which denies reads and writes. Permission bit 2d+1 is write-disable, which denies writes only.
- R5: `rsp_allow` is high only when both the page screen and the domain screen permit the access. For every valid response, exactly one of `rsp_allow` and `rsp_fault` is high.
- R6: The domain screen applies to user pages (bit 2 set) in both user and supervisor mode. It never affects pages with bit 2 clear.
- R7: Instruction fetches (`req_kind`=2'b10) are never denied by the domain screen.
- R8: When the page screen denies an access, `rsp_code` bit 4 stays 0 even if the domain screen would also deny it. Bit 4 is set only for a fault caused by the domain screen alone.
- R9: Error code layout on a fault: bit 0 is the entry's present bit, bit 1 marks a write, bit 2 marks user mode, bit 3 marks a fetch, and bit 4 marks a domain-key denial. On an allowed access the code is 0.
- R10: A write with `perm_we` high at a clock edge loads `perm_wdata`. A request given in the same cycle as the write is judged with the old contents. A request in the following cycle is judged with the new contents.
- R11: Access kind encoding: 2'b00 is read, 2'b01 is write, 2'b10 is fetch, and 2'b11 is treated exactly as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| perm_we | input | 1 | Write strobe for the permission register |
| perm_wdata | input | 32 | New permission register contents |
| req_valid | input | 1 | Request present this cycle |
| req_pte | input | 64 | Leaf page-table entry of the access |
| req_kind | input | 2 | Access kind (00 read, 01 write, 10 fetch, 11 read) |
| req_sup | input | 1 | 1 for supervisor mode, 0 for user mode |
| rsp_valid | output | 1 | Verdict present this cycle |
| rsp_allow | output | 1 | Access granted |
| rsp_fault | output | 1 | Access denied |
| rsp_code | output | 5 | Fault error code |

## Verification
Requests are driven with entries whose other bits, including bit 63 and a few middle bits, are set as noise. This shows that only bits 62:59 select the domain, and that domains 0, 3, 4, 9 and 15 resolve independently. Reads, writes, fetches and the spare kind are tried against access-disable and write-disable settings, in both modes and on both user and supervisor pages. This separates the two disable bits and shows where the domain screen applies and where it does not. Entries that fail the page screen as well as the domain screen show which screen takes precedence. A permission write issued in the same cycle as a request, followed by an identical request, separates the old register contents from the new.

// File: rtl/pkey_guard_pkg.sv
package pkey_guard_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_SPARE = 2'b11
    } acc_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } guard_state_e;

    typedef struct packed {
        logic key;
        logic fetch;
        logic user;
        logic write;
        logic present;
    } fault_code_t;

    localparam int unsigned CODE_W = $bits(fault_code_t);

endpackage

// File: rtl/pkey_perm_reg.sv
module pkey_perm_reg #(
    parameter int unsigned NUM_DOM = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [2*NUM_DOM-1:0]   wdata,
    output logic [2*NUM_DOM-1:0]   perm_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            perm_q <= '0;
        else if (we)
            perm_q <= wdata;
    end

    // R10: a write is visible one edge later
    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (perm_q == $past(wdata)));

endmodule

// File: rtl/pkey_legacy_chk.sv
module pkey_legacy_chk #(
    parameter int unsigned P_BIT = 0,
    parameter int unsigned W_BIT = 1,
    parameter int unsigned U_BIT = 2,
    parameter int unsigned LOW_W = 3
) (
    input  logic [LOW_W-1:0] pte_low,
    input  logic             is_write,
    input  logic             sup_mode,
    output logic             page_ok
);

    logic present_ok;
    logic mode_ok;
    logic write_ok;

    always_comb begin
        present_ok = pte_low[P_BIT];
        mode_ok    = sup_mode || pte_low[U_BIT];
        write_ok   = !is_write || pte_low[W_BIT];
        page_ok    = present_ok && mode_ok && write_ok;
    end

endmodule

// File: rtl/pkey_domain_chk.sv
module pkey_domain_chk #(
    parameter int unsigned KEY_W   = 4,
    localparam int unsigned NUM_DOM = 1 << KEY_W
) (
    input  logic [KEY_W-1:0]     key,
    input  logic [2*NUM_DOM-1:0] perm,
    input  logic                 user_page,
    input  logic                 is_write,
    input  logic                 is_fetch,
    output logic                 key_ok
);

    logic [NUM_DOM-1:0] acc_dis;
    logic [NUM_DOM-1:0] wr_dis;

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        assign acc_dis[d] = perm[2*d];
        assign wr_dis[d]  = perm[2*d+1];
    end

    logic deny;

    always_comb begin
        deny   = acc_dis[key] || (is_write && wr_dis[key]);
        key_ok = !user_page || is_fetch || !deny;
    end

endmodule

// File: rtl/pkey_guard.sv
module pkey_guard
    import pkey_guard_pkg::*;
#(
    parameter int unsigned PTE_W   = 64,
    parameter int unsigned KEY_W   = 4,
    parameter int unsigned KEY_LSB = 59,
    parameter int unsigned P_BIT   = 0,
    parameter int unsigned W_BIT   = 1,
    parameter int unsigned U_BIT   = 2,
    localparam int unsigned NUM_DOM = 1 << KEY_W,
    localparam int unsigned PERM_W  = 2 * NUM_DOM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              perm_we,
    input  logic [PERM_W-1:0] perm_wdata,
    input  logic              req_valid,
    input  logic [PTE_W-1:0]  req_pte,
    input  logic [1:0]        req_kind,
    input  logic              req_sup,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic              rsp_fault,
    output logic [CODE_W-1:0] rsp_code
);

    localparam int unsigned LOW_W = 3;

    guard_state_e state_q;
    guard_state_e state_d;

    logic [PERM_W-1:0] perm_q;
    acc_kind_e         kind;
    logic              is_write;
    logic              is_fetch;
    logic              page_ok;
    logic              key_ok;
    logic              grant;
    fault_code_t       code_d;

    pkey_perm_reg #(.NUM_DOM(NUM_DOM)) u_perm (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (perm_we),
        .wdata  (perm_wdata),
        .perm_q (perm_q)
    );

    always_comb begin
        kind     = acc_kind_e'(req_kind);
        is_write = (kind == ACC_WRITE);
        is_fetch = (kind == ACC_FETCH);
    end

    pkey_legacy_chk #(
        .P_BIT (P_BIT),
        .W_BIT (W_BIT),
        .U_BIT (U_BIT),
        .LOW_W (LOW_W)
    ) u_legacy (
        .pte_low  (req_pte[LOW_W-1:0]),
        .is_write (is_write),
        .sup_mode (req_sup),
        .page_ok  (page_ok)
    );

    pkey_domain_chk #(.KEY_W(KEY_W)) u_domain (
        .key       (req_pte[KEY_LSB +: KEY_W]),
        .perm      (perm_q),
        .user_page (req_pte[U_BIT]),
        .is_write  (is_write),
        .is_fetch  (is_fetch),
        .key_ok    (key_ok)
    );

    always_comb begin
        grant = page_ok && key_ok;
        code_d = '0;
        if (!grant) begin
            code_d.present = req_pte[P_BIT];
            code_d.write   = is_write;
            code_d.user    = !req_sup;
            code_d.fetch   = is_fetch;
            code_d.key     = page_ok && !key_ok;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = req_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_allow <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_code  <= '0;
        end else begin
            rsp_allow <= grant;
            rsp_fault <= !grant;
            rsp_code  <= code_d;
        end
    end

    assign rsp_valid = (state_q == ST_RESULT);

    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_allow && !rsp_fault && (rsp_code == '0)));

    a_r5_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_allow != rsp_fault));

    a_r8_key_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_code[CODE_W-1] |-> rsp_fault);

    a_r3_absent_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_pte[P_BIT]) |=> (rsp_fault && !rsp_code[CODE_W-1]));

    a_r7_fetch_no_key: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_kind == 2'b10)) |=> !rsp_code[CODE_W-1]);

    a_r9_allow_clean: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_allow |-> (rsp_code == '0));

endmodule

// File: tb/pkey_guard_bench.sv
module pkey_guard_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        perm_we = 1'b0;
    logic [31:0] perm_wdata = '0;
    logic        req_valid = 1'b0;
    logic [63:0] req_pte = '0;
    logic [1:0]  req_kind = '0;
    logic        req_sup = 1'b0;
    logic        rsp_valid;
    logic        rsp_allow;
    logic        rsp_fault;
    logic [4:0]  rsp_code;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] shadow = '0;
    logic [6:0]  exp_q[$];
    string       tag_q[$];
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkey_guard u_pkey_guard (
        .clk(clk), .rst_n(rst_n), .perm_we(perm_we), .perm_wdata(perm_wdata),
        .req_valid(req_valid), .req_pte(req_pte), .req_kind(req_kind), .req_sup(req_sup),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault), .rsp_code(rsp_code)
    );

    // entry with noise in bit 63 and bits 15:12
    function automatic logic [63:0] mkpte(input logic [3:0] key, input logic u,
                                          input logic w, input logic p);
        return 64'h8000_0000_0000_F000 | (64'(key) << 59) | {61'b0, u, w, p};
    endfunction

    function automatic logic [6:0] model(input logic [63:0] pte, input logic [1:0] kind,
                                         input logic sup, input logic [31:0] perm);
        logic p, w, u, isw, isf, pg, ad, wd, kk, al;
        logic [3:0] key;
        p = pte[0]; w = pte[1]; u = pte[2]; key = pte[62:59];
        isw = (kind == 2'b01); isf = (kind == 2'b10);
        pg = p && (sup || u) && (!isw || w);
        ad = perm[2*key]; wd = perm[2*key+1];
        kk = !u || isf || !(ad || (isw && wd));
        al = pg && kk;
        if (al) return {1'b1, 1'b0, 5'b0};
        return {1'b0, 1'b1, (pg && !kk), isf, !sup, isw, p};
    endfunction

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got allow/fault/code=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic send(input logic [63:0] pte, input logic [1:0] kind,
                        input logic sup, input string tag);
        @(negedge clk);
        perm_we = 1'b0;
        req_valid = 1'b1; req_pte = pte; req_kind = kind; req_sup = sup;
        exp_q.push_back(model(pte, kind, sup, shadow));
        tag_q.push_back(tag);
    endtask

    // request and permission write in the same cycle
    task automatic send_w(input logic [63:0] pte, input logic [1:0] kind, input logic sup,
                          input logic [31:0] nperm, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_pte = pte; req_kind = kind; req_sup = sup;
        perm_we = 1'b1; perm_wdata = nperm;
        exp_q.push_back(model(pte, kind, sup, shadow));
        tag_q.push_back(tag);
        shadow = nperm;
    endtask

    task automatic wr_perm(input logic [31:0] nperm);
        @(negedge clk);
        req_valid = 1'b0; perm_we = 1'b1; perm_wdata = nperm;
        shadow = nperm;
        @(negedge clk);
        perm_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0; perm_we = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    // monitor: pops the scoreboard as responses arrive
    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected response", 7'b1, 7'b0);
                end else begin
                    check(tag_q.pop_front(), {rsp_allow, rsp_fault, rsp_code}, exp_q.pop_front());
                end
            end else begin
                check("R2 idle outputs", {rsp_allow, rsp_fault, rsp_code}, 7'b0);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: run hung, got no end expected end");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        check("R1 reset outputs", {rsp_valid, rsp_allow, rsp_fault, rsp_code[3:0]}, 7'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: all domains open after reset
        send(mkpte(4'd5, 1, 1, 1), 2'b01, 1'b0, "R1 reset perm allows write");
        // R3 page screen
        send(mkpte(4'd5, 1, 1, 0), 2'b00, 1'b0, "R3 not present");
        send(mkpte(4'd5, 0, 1, 1), 2'b00, 1'b0, "R3 user to supervisor page");
        send(mkpte(4'd5, 1, 0, 1), 2'b01, 1'b0, "R3 user write read-only");
        send(mkpte(4'd5, 0, 0, 1), 2'b01, 1'b1, "R3 sup write read-only");
        send(mkpte(4'd5, 0, 1, 1), 2'b00, 1'b1, "R3 sup read sup page ok");
        idle(2);

        // R4: access-disable on domain 3 (bit 6), write-disable on domain 9 (bit 19)
        wr_perm(32'h0008_0040);
        send(mkpte(4'd3, 1, 1, 1), 2'b00, 1'b0, "R4 AD blocks read");
        send(mkpte(4'd3, 1, 1, 1), 2'b01, 1'b0, "R4 AD blocks write");
        send(mkpte(4'd4, 1, 1, 1), 2'b01, 1'b0, "R4 neighbour domain open");
        send(mkpte(4'd9, 1, 1, 1), 2'b00, 1'b0, "R4 WD allows read");
        send(mkpte(4'd9, 1, 1, 1), 2'b01, 1'b0, "R4 WD blocks write");
        // R6
        send(mkpte(4'd3, 1, 1, 1), 2'b00, 1'b1, "R6 sup access user page checked");
        send(mkpte(4'd3, 0, 1, 1), 2'b01, 1'b1, "R6 sup page not key checked");
        // R7
        send(mkpte(4'd3, 1, 1, 1), 2'b10, 1'b0, "R7 fetch ignores AD");
        // R8
        send(mkpte(4'd3, 1, 1, 0), 2'b00, 1'b0, "R8 absent beats key");
        send(mkpte(4'd9, 1, 0, 1), 2'b01, 1'b0, "R8 read-only beats key");
        // R11
        send(mkpte(4'd9, 1, 1, 1), 2'b11, 1'b0, "R11 spare kind acts as read");
        send(mkpte(4'd3, 1, 1, 1), 2'b11, 1'b1, "R11 spare kind hits AD");
        idle(1);

        // R4 edge domains: AD on 15 (bit 30), WD on 0 (bit 1)
        wr_perm(32'h4000_0002);
        send(mkpte(4'd15, 1, 1, 1), 2'b00, 1'b0, "R4 domain 15 AD");
        send(mkpte(4'd0, 1, 1, 1), 2'b01, 1'b0, "R4 domain 0 WD");
        send(mkpte(4'd3, 1, 1, 1), 2'b00, 1'b0, "R5 domain 3 reopened");
        // R10: write lands for the next cycle only
        send_w(mkpte(4'd7, 1, 1, 1), 2'b00, 1'b0, 32'h0000_4000, "R10 same cycle uses old");
        send(mkpte(4'd7, 1, 1, 1), 2'b00, 1'b0, "R10 next cycle uses new");
        idle(3);

        if (exp_q.size() != 0) check("R2 responses missing", 7'(exp_q.size()), 7'b0);
        finish_run();
    end

endmodule